// File: doc/BRIEF.md
# Joypad-Line Packet Receiver

This block sits behind the byte-wide joypad register. Software uses that register to send a bit-serial command stream. It writes patterns to the two controller-select bits, and the block decodes each pattern as one of four symbols: reset, arm, zero and one. A reset symbol clears a packet buffer of `PKT_BYTES` bytes. Each arm followed by a data symbol stores one bit. An armed zero that arrives after the last bit position is the stop bit, and it closes the packet.

The first packet of a command carries a header byte. Its upper five bits hold a command code and its lower three bits hold the number of packets in the command. The block gathers packets until that number has arrived. It then raises a one-cycle strobe and presents the code, the packet count and all gathered bytes on its outputs.

The same block also drives the read side of the register. When the player-count command arrives, the block changes how many controllers it reports. A read taken while both select bits are high steps through the controller index.

Top module: `padlink_rx`

## Requirements
- R1: After reset `cmd_valid` is 0, the select field is 00, one player is active with index 0, and a read returns 0xCF while no key is pressed.
- R2: A write keeps only bits 5:4 as the select field. A read returns 1 in bits 7:6 and the select field in bits 5:4.
- R3: While `en` is 1, a write with select 00 empties the packet buffer, clears the armed state and moves the bit position to one before the first bit. Bits sent before it have no effect on the next packet.
- R4: While `en` is 1, a write with select 11 arms the receiver only if it is not already armed, and advances the bit position by one. Further select-11 writes while armed change nothing.
- R5: An armed write with select 10 stores a 0 bit and an armed write with select 01 stores a 1 bit; both disarm. The same writes while disarmed are ignored.
- R6: Bit position k of a packet lands in byte k/8, bit k%8 (least significant bit first), for positions 0 to 8*`PKT_BYTES`-1. Packet p of a command occupies bytes 16p to 16p+15 of `cmd_data`, and byte i occupies `cmd_data[8i+7:8i]`.
- R7: Once all 8*`PKT_BYTES` bits have been taken, an arm followed by select 10 completes the packet. An armed select-01 write at that point does not complete it.
- R8: For the first packet, bits 7:3 of byte 0 are the command code and bits 2:0 are the packet count. A packet whose count is 0 is dropped and raises no strobe.
- R9: `cmd_valid` is high for exactly one cycle. That cycle is the second clock edge after the write that completes the last packet of the command, and no earlier packet raises it.
- R10: Command code 0x11 sets the player count from bits 1:0 of byte 1 (0→1, 1→2, 2→1, 3→4) and sets the current player to 0.
- R11: While `en` is 1 and the select field is 11, a read advances the current player modulo the player count and returns the inverted new index in bits 3:0. Otherwise the bits 3:0 hold the inverted OR of the selected key groups of the current player: select bit 5 low adds keys 7:4, and select bit 4 low adds keys 3:0.
- R12: While `en` is 0, writes change only the select field, no packet is collected, and reads never advance the current player.
- R13: `cmd_code`, `cmd_npkt` and `cmd_data` keep their values from one command until a packet of the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables packet reception and player cycling |
| wr_en | input | 1 | Joypad register write strobe |
| wr_data | input | 8 | Write data; only bits 5:4 are used |
| rd_en | input | 1 | Joypad register read strobe (advances the player) |
| rd_data | output | 8 | Read value, valid while `rd_en` is high |
| pad_keys | input | NUM_PADS*8 | Key state per player, active high, player p in bits 8p+7:8p |
| cmd_valid | output | 1 | One-cycle strobe for a complete command |
| cmd_code | output | 5 | Command code of the latest command |
| cmd_npkt | output | CNT_W | Packet count of the latest command |
| cmd_data | output | (2^CNT_W-1)*PKT_BYTES*8 | Gathered command bytes, byte i at bits 8i+7:8i |

## Verification
The bench builds the block with 16-byte packets, a 3-bit packet count and four controllers. These values make it possible to reach the full 128-bit stop position, a three-packet command and every value of the player-count mapping, including the four-player rotation that wraps back to index 0. A behavioural model follows each write and is compared with the strobe on every clock. Noise in the unused write bits, duplicate arms, stray data symbols and a late one-symbol at the stop position all stress the framing.

// File: rtl/padlink_pkg.sv
package padlink_pkg;

  typedef enum logic [1:0] {
    SYM_RESET = 2'b00,
    SYM_ONE   = 2'b01,
    SYM_ZERO  = 2'b10,
    SYM_ARM   = 2'b11
  } sym_e;

  // player-count request field to number of active controllers
  function automatic logic [2:0] players_from_req(input logic [1:0] req);
    case (req)
      2'd1:    return 3'd2;
      2'd3:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  // register read value: keys and player index are active low
  function automatic logic [7:0] pad_read_value(input logic [1:0] sel,
                                                input logic [7:0] keys,
                                                input logic [3:0] pid_nib,
                                                input logic       show_pid);
    logic [3:0] act;
    act = 4'h0;
    if (!sel[1]) act = act | keys[7:4];
    if (!sel[0]) act = act | keys[3:0];
    if (show_pid) act = act | pid_nib;
    return {2'b11, sel, ~act};
  endfunction

endpackage

// File: rtl/padlink_sym.sv
module padlink_sym
  import padlink_pkg::*;
#(
  parameter int PKT_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  output logic [1:0]             sel_q,
  output logic [PKT_BYTES*8-1:0] pkt_buf,
  output logic                   pkt_done
);
  localparam int PKT_BITS = PKT_BYTES * 8;
  localparam int IDX_W    = $clog2(PKT_BITS);
  localparam int PTR_W    = $clog2(PKT_BITS + 2) + 1;
  localparam logic signed [PTR_W-1:0] PTR_END = PTR_W'(PKT_BITS);

  logic signed [PTR_W-1:0] ptr_q;
  logic                    armed_q;
  logic [IDX_W-1:0]        bit_idx;

  // decoded symbol events, named for the assertions
  logic act, sym_reset, sym_arm, sym_zero, sym_one, sym_stop;
  assign act       = wr_en && en;
  assign sym_reset = act && (wr_sel == SYM_RESET);
  assign sym_arm   = act && (wr_sel == SYM_ARM) && !armed_q;
  assign sym_zero  = act && (wr_sel == SYM_ZERO) && armed_q && (ptr_q < PTR_END);
  assign sym_one   = act && (wr_sel == SYM_ONE)  && armed_q && (ptr_q < PTR_END);
  assign sym_stop  = act && (wr_sel == SYM_ZERO) && armed_q && (ptr_q == PTR_END);
  assign bit_idx   = ptr_q[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 2'b00;
      ptr_q    <= '1;
      armed_q  <= 1'b0;
      pkt_buf  <= '0;
      pkt_done <= 1'b0;
    end else begin
      pkt_done <= sym_stop;
      if (wr_en) sel_q <= wr_sel;
      if (sym_reset) begin
        ptr_q   <= '1;
        armed_q <= 1'b0;
        pkt_buf <= '0;
      end else if (sym_arm) begin
        armed_q <= 1'b1;
        ptr_q   <= ptr_q + PTR_W'(1);
      end else if (sym_one) begin
        pkt_buf[bit_idx] <= 1'b1;
        armed_q          <= 1'b0;
      end else if (sym_zero || sym_stop) begin
        armed_q <= 1'b0;
      end
    end
  end

  // R4
  hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && act && wr_sel == 2'b11) |=> $stable(ptr_q));

  // R7
  stop_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> ($past(wr_en) && $past(en) && $past(wr_sel) == 2'b10));

  // R3
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && wr_sel == 2'b00) |=> (pkt_buf == '0));

endmodule

// File: rtl/padlink_asm.sv
module padlink_asm #(
  parameter int PKT_BYTES = 16,
  parameter int CNT_W     = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   pkt_done,
  input  logic [PKT_BYTES*8-1:0]                 pkt_buf,
  output logic                                   cmd_valid,
  output logic [4:0]                             cmd_code,
  output logic [CNT_W-1:0]                       cmd_npkt,
  output logic [((1<<CNT_W)-1)*PKT_BYTES*8-1:0]  cmd_data
);
  localparam int PKT_BITS = PKT_BYTES * 8;
  localparam int MAX_PKTS = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] idx_q;
  logic             first_pkt, accept, last_pkt;
  logic [CNT_W-1:0] head_cnt, eff_cnt;

  assign head_cnt  = pkt_buf[CNT_W-1:0];
  assign first_pkt = (idx_q == '0);
  assign eff_cnt   = first_pkt ? head_cnt : cmd_npkt;
  assign accept    = pkt_done && (!first_pkt || head_cnt != '0);
  assign last_pkt  = accept && (({1'b0, idx_q} + (CNT_W+1)'(1)) == {1'b0, eff_cnt});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_npkt  <= '0;
    end else begin
      cmd_valid <= last_pkt;
      if (accept) begin
        if (first_pkt) begin
          cmd_code <= pkt_buf[7:3];
          cmd_npkt <= head_cnt;
        end
        idx_q <= last_pkt ? '0 : idx_q + CNT_W'(1);
      end
    end
  end

  for (genvar g = 0; g < MAX_PKTS; g++) begin : g_slot
    logic [PKT_BITS-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else if (accept && idx_q == CNT_W'(g)) slot_q <= pkt_buf;
    end
    assign cmd_data[g*PKT_BITS +: PKT_BITS] = slot_q;
  end

  // R9
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R13
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_done |=> ($stable(cmd_data) && $stable(cmd_code)));

  // R8
  empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && idx_q == '0 && pkt_buf[CNT_W-1:0] == '0) |=> (!cmd_valid && idx_q == '0));

endmodule

// File: rtl/padlink_pad.sv
module padlink_pad
  import padlink_pkg::*;
#(
  parameter int         NUM_PADS   = 4,
  parameter logic [4:0] MULTI_CODE = 5'h11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  rd_en,
  input  logic [1:0]            sel,
  input  logic [NUM_PADS*8-1:0] pad_keys,
  input  logic                  cmd_valid,
  input  logic [4:0]            cmd_code,
  input  logic [1:0]            req_bits,
  output logic [7:0]            rd_data
);
  localparam int PID_W = $clog2(NUM_PADS);
  localparam int CPW   = $clog2(NUM_PADS + 1);

  logic [PID_W-1:0] cur_q, cur_adv, cur_view;
  logic [CPW-1:0]   cnt_q;
  logic             cycle_rd;
  logic [7:0]       view_keys;

  assign cycle_rd  = en && (sel == 2'b11);
  assign cur_adv   = (({1'b0, cur_q} + (PID_W+1)'(1)) >= (PID_W+1)'(cnt_q)) ? '0
                                                                             : cur_q + PID_W'(1);
  assign cur_view  = cycle_rd ? cur_adv : cur_q;
  assign view_keys = pad_keys[{cur_view, 3'b000} +: 8];
  assign rd_data   = pad_read_value(sel, view_keys, 4'(cur_view), cycle_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      cnt_q <= CPW'(1);
    end else if (cmd_valid && cmd_code == MULTI_CODE) begin
      cnt_q <= CPW'(players_from_req(req_bits));
      cur_q <= '0;
    end else if (rd_en && cycle_rd) begin
      cur_q <= cur_adv;
    end
  end

  // R11
  cur_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cur_q} < (PID_W+1)'(cnt_q)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cmd_valid) |=> $stable(cur_q));

  // R10
  count_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CPW'(1) || cnt_q == CPW'(2) || cnt_q == CPW'(4)));

endmodule

// File: rtl/padlink_rx.sv
module padlink_rx #(
  parameter int         PKT_BYTES  = 16,
  parameter int         CNT_W      = 3,
  parameter int         NUM_PADS   = 4,
  parameter logic [4:0] MULTI_CODE = 5'h11
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  en,
  input  logic                                  wr_en,
  input  logic [7:0]                            wr_data,
  input  logic                                  rd_en,
  output logic [7:0]                            rd_data,
  input  logic [NUM_PADS*8-1:0]                 pad_keys,
  output logic                                  cmd_valid,
  output logic [4:0]                            cmd_code,
  output logic [CNT_W-1:0]                      cmd_npkt,
  output logic [((1<<CNT_W)-1)*PKT_BYTES*8-1:0] cmd_data
);
  logic [1:0]             sel_q;
  logic [PKT_BYTES*8-1:0] pkt_buf;
  logic                   pkt_done;
  logic                   unused_wr;

  assign unused_wr = ^{wr_data[7:6], wr_data[3:0]};

  padlink_sym #(.PKT_BYTES(PKT_BYTES)) u_sym (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_sel(wr_data[5:4]),
    .sel_q(sel_q), .pkt_buf(pkt_buf), .pkt_done(pkt_done)
  );

  padlink_asm #(.PKT_BYTES(PKT_BYTES), .CNT_W(CNT_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt_buf(pkt_buf),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_npkt(cmd_npkt), .cmd_data(cmd_data)
  );

  padlink_pad #(.NUM_PADS(NUM_PADS), .MULTI_CODE(MULTI_CODE)) u_pad (
    .clk(clk), .rst_n(rst_n), .en(en), .rd_en(rd_en), .sel(sel_q),
    .pad_keys(pad_keys), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .req_bits(cmd_data[9:8]), .rd_data(rd_data)
  );

endmodule

// File: tb/padlink_rx_tb_top.sv
`timescale 1ns/1ps
module padlink_rx_tb_top;
  localparam int PB   = 16;
  localparam int CW   = 3;
  localparam int NP   = 4;
  localparam int MAXB = 7 * PB;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [NP*8-1:0] pad_keys = '0;
  logic cmd_valid;
  logic [4:0] cmd_code;
  logic [CW-1:0] cmd_npkt;
  logic [MAXB*8-1:0] cmd_data;

  padlink_rx #(.PKT_BYTES(PB), .CNT_W(CW), .NUM_PADS(NP), .MULTI_CODE(5'h11)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pad_keys(pad_keys), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_npkt(cmd_npkt), .cmd_data(cmd_data)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, issue_cycle = -10;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural model state
  int m_sel = 0, m_ptr = -1, m_idx = 0, m_cnt = 0, m_code = 0, m_players = 1, m_cur = 0;
  bit m_armed = 0;
  logic [PB*8-1:0] m_buf = '0;
  logic [7:0] m_cmd [MAXB];
  int pmap [4] = '{1, 2, 1, 4};
  logic [7:0] pk [PB];
  bit dup_arm = 0, dup_data = 0, one_at_end = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic data_chk(input string tag);
    int bad_i;
    bad_i = -1;
    for (int i = MAXB - 1; i >= 0; i--)
      if (cmd_data[i*8 +: 8] !== m_cmd[i]) bad_i = i;
    if (bad_i < 0) chk(tag, 0, 0);
    else chk({tag, $sformatf(" byte %0d", bad_i)}, cmd_data[bad_i*8 +: 8], m_cmd[bad_i]);
  endtask

  // compare the strobe on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 strobe timing", cmd_valid, (cyc == issue_cycle));
      if (cyc == issue_cycle) begin
        chk("R8 command code", cmd_code, m_code);
        chk("R8 packet count", cmd_npkt, m_cnt);
        data_chk("R6 command bytes");
      end
    end
  end

  task automatic pkt_complete();
    logic [7:0] b0;
    b0 = m_buf[7:0];
    if (m_idx == 0) begin
      if (b0[2:0] == 3'd0) return;
      m_code = b0[7:3];
      m_cnt  = b0[2:0];
    end
    for (int i = 0; i < PB; i++) m_cmd[m_idx*PB + i] = m_buf[i*8 +: 8];
    m_idx++;
    if (m_idx == m_cnt) begin
      m_idx = 0;
      issue_cycle = cyc + 2;
      if (m_code == 17) begin
        m_players = pmap[m_cmd[1] & 8'h03];
        m_cur = 0;
      end
    end
  endtask

  task automatic model_write(input logic [7:0] v);
    m_sel = (v >> 4) & 3;
    if (!en) return;
    case (m_sel)
      0: begin m_ptr = -1; m_armed = 0; m_buf = '0; end
      3: if (!m_armed) begin m_armed = 1; m_ptr++; end
      2: if (m_armed && m_ptr < PB*8) m_armed = 0;
         else if (m_armed && m_ptr == PB*8) begin m_armed = 0; pkt_complete(); end
      default: if (m_armed && m_ptr < PB*8) begin m_buf[m_ptr] = 1'b1; m_armed = 0; end
    endcase
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    model_write(v);
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag);
    bit flag;
    int view, keys, grp;
    @(negedge clk);
    rd_en = 1'b1;
    #1;
    flag = en && (m_sel == 3);
    view = flag ? (m_cur + 1) % m_players : m_cur;
    keys = (pad_keys >> (view * 8)) & 8'hFF;
    grp = 0;
    if ((m_sel & 2) == 0) grp = grp | (keys >> 4);
    if ((m_sel & 1) == 0) grp = grp | (keys & 15);
    if (flag) grp = grp | view;
    chk(tag, rd_data, 8'hC0 | (m_sel << 4) | (~grp & 15));
    if (flag) m_cur = view;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic hold_chk(input string tag);
    @(negedge clk);
    chk({tag, " code"}, cmd_code, m_code);
    data_chk({tag, " bytes"});
  endtask

  task automatic send_packet();
    bit b;
    wr(8'hC7);
    for (int i = 0; i < PB*8; i++) begin
      b = pk[i/8][i%8];
      wr(8'h3C);
      if (dup_arm && (i % 5 == 0)) wr(8'hF3);
      wr(b ? 8'h59 : 8'hA6);
      if (dup_data && (i % 7 == 0)) wr(b ? 8'h1F : 8'h2F);
    end
    wr(8'h3C);
    if (one_at_end) wr(8'h59);
    wr(8'hA6);
    idle(4);
  endtask

  task automatic fill(input logic [7:0] head, input logic [7:0] b1, input int seed);
    pk[0] = head; pk[1] = b1;
    for (int i = 2; i < PB; i++) pk[i] = 8'((i * 37 + seed) & 255);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < MAXB; i++) m_cmd[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R1
    chk("R1 reset strobe", cmd_valid, 0);
    rd_chk("R1 reset read");
    // R2 with receiver disabled
    wr(8'hDA);
    rd_chk("R2 select readback");
    pad_keys = {8'hF0, 8'h81, 8'h3C, 8'h5A};
    // R11 key groups, player 0
    wr(8'h2B); rd_chk("R11 low key group");
    wr(8'h1E); rd_chk("R11 high key group");
    en = 1'b1;
    wr(8'hC0); rd_chk("R11 both key groups");
    // R3 stray bits before a packet; R4 and R5 noise inside it
    wr(8'h3C); wr(8'h59); wr(8'h3C); wr(8'h59);
    fill(8'h19, 8'h44, 5);
    dup_arm = 1; dup_data = 1;
    send_packet();
    dup_arm = 0; dup_data = 0;
    hold_chk("R13 after single");
    // R7 one-symbol at the stop position
    fill(8'hF9, 8'h0F, 11);
    one_at_end = 1;
    send_packet();
    one_at_end = 0;
    // R8 zero count dropped
    fill(8'h50, 8'hAA, 3);
    send_packet();
    hold_chk("R13 after dropped packet");
    // R9 three-packet command
    fill(8'h4B, 8'h12, 7); send_packet();
    fill(8'h00, 8'h34, 9); send_packet();
    fill(8'hFF, 8'h56, 1); send_packet();
    // R3 partial packet then reset: outputs hold
    wr(8'hC7); wr(8'h3C); wr(8'h59);
    hold_chk("R13 after partial");
    // R10 four players
    fill(8'h89, 8'h03, 2); send_packet();
    wr(8'h30);
    for (int k = 0; k < 5; k++) rd_chk("R10 four player cycle");
    wr(8'h20); rd_chk("R11 keys of current player");
    wr(8'h10); rd_chk("R11 other group of current player");
    // R12 disabled: no cycling, no reception
    wr(8'h30);
    en = 1'b0;
    rd_chk("R12 no cycle while disabled");
    rd_chk("R12 no cycle while disabled");
    fill(8'h89, 8'h01, 4); send_packet();
    en = 1'b1;
    idle(2);
    wr(8'h30);
    for (int k = 0; k < 4; k++) rd_chk("R12 four players kept");
    // R10 other mappings
    fill(8'h89, 8'h01, 6); send_packet();
    wr(8'h30);
    for (int k = 0; k < 3; k++) rd_chk("R10 two player cycle");
    fill(8'h89, 8'h02, 8); send_packet();
    wr(8'h30);
    for (int k = 0; k < 2; k++) rd_chk("R10 map two to one");
    fill(8'h89, 8'h00, 10); send_packet();
    wr(8'h30);
    rd_chk("R10 map zero to one");
    hold_chk("R13 final");
    idle(4);
    finish_run();
  end
endmodule